// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It works with three analog parts outside it: a track-and-hold stage, a DAC and a comparator. A one-cycle `go` request, accepted while the block is idle, starts a conversion. The block first raises `sample` for a programmable number of cycles so that the hold stage can acquire the input. It then runs a binary search, one bit per step, starting at the most significant bit and ending at the least significant bit.

In each step the block presents a trial code on `dac_code`. The trial code is the bits already decided plus the current bit set to one. The block holds that code for a programmable settle interval that covers the DAC and the comparator. On the last cycle of the interval it reads `cmp_hi`, which is high when the DAC voltage is above the held input. If `cmp_hi` is high, the current bit is cleared. Otherwise it is kept.

After the last bit, `data` takes the final code and `done` pulses for one cycle. A conversion always takes the same number of cycles. When a bipolar conversion is requested, the result is given relative to mid-scale.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, `done`, `sample` and `busy` are low, and `data` and `dac_code` are zero.
- R2: A `go` that is high at a clock edge while the block is idle is accepted. `sample` is high for exactly SAMPLE_CYC cycles, starting in the cycle after that edge.
- R3: In the first cycle after `sample` falls, `dac_code` holds only the most significant bit set.
- R4: Each trial code stays on `dac_code` for exactly SETTLE_CYC cycles. `cmp_hi` is read on the last of those cycles, and a high value clears the bit under test. The next trial is the resolved bits plus the next lower bit set.
- R5: If the comparator is an ideal quantiser, `data` equals the input divided by one LSB, rounded down. For example, with 3 bits and an input between 2 and 3 LSB, the result is 010.
- R6: `done` is high in the cycle that begins SAMPLE_CYC + WIDTH*SETTLE_CYC clock edges after the edge that accepted `go`.
- R7: `done` is high for a single cycle per conversion.
- R8: `data` changes only in the cycle in which `done` is high. It then keeps its value through the whole next conversion.
- R9: A `go` that arrives while `busy` is high, including the `done` cycle, is ignored. It neither restarts the conversion nor changes its result or its timing.
- R10: `bipolar` is sampled together with an accepted `go`. When it is 1, `data` is the raw code with its most significant bit inverted. This gives the two's-complement value relative to mid-scale, so the raw code 2^(WIDTH-1) reads as zero.
- R11: `busy` is high from the cycle after `go` is accepted through the `done` cycle. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Conversion request, accepted while idle |
| bipolar | input | 1 | Result format for the requested conversion (1 = relative to mid-scale) |
| cmp_hi | input | 1 | Comparator output, high when the DAC voltage is above the held input |
| sample | output | 1 | Track-and-hold acquire command |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| data | output | WIDTH | Converted result |

## Verification
The hardest case to reach from the ports is a `go` that arrives in the middle of a conversion, and above all one that arrives in the exact cycle of the `done` pulse. A block that restarts there, or that lets the late request slip into the next conversion, still gives a correct code. Only its timing shows the fault.

The bench fires a second `go` at a randomly chosen cycle of a conversion, and in some runs forces that cycle to be the `done` cycle. It then checks the latency, the result, and that `busy` is low afterwards. Every trial code is also compared cycle by cycle against the expected binary-search path. The input values are random, plus directed values at zero, full scale, mid-scale and exact code boundaries.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2,
    ST_DONE   = 2'd3
  } sar_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] resolved,
  output logic             last_bit
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] ptr_q, ptr_d;

  // The bit under test is cleared when the DAC lands above the held input.
  assign resolved = cmp_hi ? (trial_q & ~ptr_q) : trial_q;

  always_comb begin
    trial_d = trial_q;
    ptr_d   = ptr_q;
    if (start) begin
      trial_d = MSB_ONLY;
      ptr_d   = MSB_ONLY;
    end else if (step) begin
      ptr_d   = ptr_q >> 1;
      trial_d = resolved | (ptr_q >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
    end else begin
      trial_q <= trial_d;
      ptr_q   <= ptr_d;
    end
  end

  assign trial    = trial_q;
  assign last_bit = ptr_q[0];
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bipolar,
  input  logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] data
);
  logic [WIDTH-1:0] data_q, data_d, fmt;

  // Mid-scale becomes zero: flip the top bit for the signed view.
  assign fmt = bipolar ? {~code[WIDTH-1], code[WIDTH-2:0]} : code;

  always_comb begin
    data_d = data_q;
    if (load) data_d = fmt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data = data_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             bipolar,
  input  logic             cmp_hi,
  output logic             sample,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] data
);
  import sar_adc_pkg::*;

  localparam int unsigned TMAX = max2(SAMPLE_CYC, SETTLE_CYC);
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] SAMP_LOAD = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] SETL_LOAD = CW'(SETTLE_CYC - 1);

  sar_state_e state_q, state_d;
  logic bip_q, bip_d;
  logic tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic code_start, code_step, res_load, last_bit;
  logic [WIDTH-1:0] trial, resolved;

  always_comb begin
    state_d    = state_q;
    bip_d      = bip_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    code_start = 1'b0;
    code_step  = 1'b0;
    res_load   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d  = ST_SAMPLE;
          bip_d    = bipolar;
          tmr_load = 1'b1;
          tmr_val  = SAMP_LOAD;
        end
      end
      ST_SAMPLE: begin
        if (tmr_zero) begin
          state_d    = ST_TRIAL;
          code_start = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = SETL_LOAD;
        end
      end
      ST_TRIAL: begin
        if (tmr_zero) begin
          code_step = 1'b1;
          if (last_bit) begin
            state_d  = ST_DONE;
            res_load = 1'b1;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = SETL_LOAD;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bip_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bip_q   <= bip_d;
    end
  end

  sar_step_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sar_code_reg #(.WIDTH(WIDTH)) code_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (code_start),
    .step     (code_step),
    .cmp_hi   (cmp_hi),
    .trial    (trial),
    .resolved (resolved),
    .last_bit (last_bit)
  );

  sar_result_reg #(.WIDTH(WIDTH)) result_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (res_load),
    .bipolar (bip_q),
    .code    (resolved),
    .data    (data)
  );

  assign sample   = (state_q == ST_SAMPLE);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign dac_code = trial;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             sample,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] dac_code
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_sample_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (busy && !done));

  a_r8_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> done);

  a_r3_first_trial_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample) |-> (dac_code == MSB_ONLY));

  a_r11_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r9_go_at_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done && go) |=> !busy);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .go       (go),
  .sample   (sample),
  .busy     (busy),
  .done     (done),
  .data     (data),
  .dac_code (dac_code)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  localparam int W  = 8;
  localparam int S  = 4;
  localparam int T  = 3;
  localparam int L  = S + W*T + 1;   // negedges from go drive to done
  localparam int FS = (1 << W) * 4;  // input in quarter-LSB units

  logic clk = 1'b0;
  logic rst_n, go, bipolar, cmp_hi;
  logic sample, busy, done;
  logic [W-1:0] dac_code, data;
  int vin_q;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  // Ideal quantiser: DAC voltage (code*LSB) above held input.
  always_comb cmp_hi = ((int'(dac_code) * 4) > vin_q);

  sar_adc_ctrl #(.WIDTH(W), .SAMPLE_CYC(S), .SETTLE_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .bipolar(bipolar), .cmp_hi(cmp_hi),
    .sample(sample), .dac_code(dac_code), .busy(busy), .done(done), .data(data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_trial(input int raw, input int c);
    int k = W - 1 - (c - S - 1) / T;
    int upper = raw & ~((1 << (k + 1)) - 1);
    return upper | (1 << k);
  endfunction

  task automatic convert(input int vin, input bit bip, input int go_again_at);
    int raw = vin >> 2;
    int expv = bip ? (raw ^ (1 << (W - 1))) : raw;
    int prev, done_at, done_cnt, samp_cnt;
    bit seq_bad, busy_bad, data_bad;
    int bad_act, bad_exp;
    vin_q = vin;
    @(negedge clk);
    prev = int'(data);
    go = 1'b1; bipolar = bip;
    done_at = -1; done_cnt = 0; samp_cnt = 0;
    seq_bad = 0; busy_bad = 0; data_bad = 0; bad_act = 0; bad_exp = 0;
    for (int c = 1; c <= L + 1; c++) begin
      @(negedge clk);
      bipolar = ~bip;
      go = (c == go_again_at);
      if (sample) samp_cnt++;
      if (c > S && c <= S + W*T && int'(dac_code) != exp_trial(raw, c)) begin
        if (!seq_bad) begin bad_act = int'(dac_code); bad_exp = exp_trial(raw, c); end
        seq_bad = 1;
      end
      if (c <= L && !busy) busy_bad = 1;
      if (done) begin done_cnt++; if (done_at < 0) done_at = c; end
      if (c < L && int'(data) != prev) data_bad = 1;
    end
    go = 1'b0;
    if (bip) check(int'(data) == expv, "R10 bipolar result", int'(data), expv);
    else     check(int'(data) == expv, "R5 result", int'(data), expv);
    check(done_at == L, "R6 latency", done_at, L);
    check(done_cnt == 1, "R7 done width", done_cnt, 1);
    check(samp_cnt == S, "R2 sample cycles", samp_cnt, S);
    check(!seq_bad, "R4 trial sequence (R3 first trial)", bad_act, bad_exp);
    check(!busy_bad && !busy, "R11 busy window", busy, 0);
    check(!data_bad, "R8 data held", int'(data_bad), 0);
    if (go_again_at > 0)
      check(!busy && done_at == L, "R9 go while busy ignored", busy, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7474));
    rst_n = 1'b0; go = 1'b0; bipolar = 1'b0; vin_q = 0;
    repeat (3) @(negedge clk);
    check(!done && !sample && !busy && data == '0 && dac_code == '0,
          "R1 reset state", int'(data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !sample && !busy && data == '0 && dac_code == '0,
          "R1 after release", int'(dac_code), 0);
    // directed: 2.5 LSB, zero, full scale, mid-scale, boundary
    convert(10, 1'b0, 0);
    convert(0, 1'b0, 0);
    convert(FS - 1, 1'b0, 0);
    convert(FS / 2, 1'b1, 0);
    convert(FS / 2 - 1, 1'b1, 0);
    convert(4 * 85, 1'b0, 0);
    convert(4 * 85 - 1, 1'b0, 10);
    convert(123, 1'b0, L);           // R9: go in the done cycle
    for (int i = 0; i < 60; i++) begin
      int v = int'($urandom % FS);
      bit b = 1'($urandom % 2);
      int g = (($urandom % 3) == 0) ? int'(2 + $urandom % (L - 1)) : 0;
      convert(v, b, g);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule